// File: doc/BRIEF.md
# Configurable Programmable-Logic Pad Cell

This block is the digital model of one user-configurable pad cell at the edge of a programmable logic array. A small static configuration word sets its behaviour. The core always sees the raw pad level. It also sees a stored copy of that level, held by an element that works as an edge-triggered flip-flop or as a level-sensitive latch. On the output side, the pad is driven through a three-state buffer. The value comes either from an output flip-flop or straight from the core, and both the data and the three-state control can be inverted.

Two clock lines are shared by every cell on the array edge. The input element and the output element each pick one of the two lines. The clock sense (normal or inverted) belongs to the line and not to the cell, so all cells on one line agree on which edge or level is active.

The configuration word is loaded through a write port while a configuration-active signal is high. Both storage elements are forced to 0 while configuration is active or while the active-low global reset is low.

Top module: `pio_cell`

## Requirements
- R1: `core_i` always equals the level currently present on `pad`, whether the cell or an external source drives it.
- R2: With configuration bit 5 = 0 (flip-flop mode), `core_q` takes the pad level on each rising edge of the selected input line when that line's sense bit is 0, and on each falling edge when it is 1. At all other times it holds.
- R3: With configuration bit 5 = 1 (latch mode), `core_q` follows the pad while the selected input line is low (sense bit 0) or high (sense bit 1). In the opposite level it holds.
- R4: Configuration bit 6 is the clock-sense bit of line 0 and bit 7 is the clock-sense bit of line 1. Each sense bit applies to both storage elements whenever they use that line.
- R5: Configuration bit 4 selects the line (0 or 1) that clocks the input element. Bit 3 selects the line that clocks the output flip-flop.
- R6: While `rst_n` is low or `cfg_active` is high, the input element and the output flip-flop both read 0.
- R7: Configuration bit 2 = 1 takes the driven pad value from the output flip-flop. Bit 2 = 0 takes it directly from `core_o`.
- R8: Configuration bit 1 = 1 inverts the selected output value before it reaches the pad.
- R9: The effective three-state control is `core_t` XOR configuration bit 0. When it is 1, the pad is released to Z. When it is 0, the cell drives the pad.
- R10: The output flip-flop captures `core_o` on the active edge of its selected line, using that line's sense bit. At all other times it holds.
- R11: On a rising `cfg_clk` edge, the configuration word loads from `cfg_wdata` only when both `cfg_active` and `cfg_we` are high. A write strobe with `cfg_active` low is ignored. When `rst_n` is low at a rising `cfg_clk` edge, the word clears to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Clock for the configuration write port |
| rst_n | input | 1 | Active-low global reset |
| cfg_active | input | 1 | High while the array is being configured; also clears storage |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration word to load |
| clk_line | input | 2 | The two shared clock lines of the array edge |
| core_o | input | 1 | Output data from the core |
| core_t | input | 1 | Three-state control from the core, before optional inversion |
| core_i | output | 1 | Unregistered pad level to the core |
| core_q | output | 1 | Stored pad level to the core |
| pad | inout | 1 | Package pad |

## Verification
A wrong input element shows on `core_q` at the first sample after the offending clock step or pad change. Examples are a latch that is open in the wrong level, a flip-flop on the wrong edge, or the wrong line. A wrong output flip-flop, inversion or three-state decision shows on `pad` in the same sample. When the cell should release the pad, the bench drives a random level, so a cell that still drives produces a level the model does not expect. Configurations and reset are changed mid-run, so a stale configuration or a missed clear shows within one cycle of the change.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
package pio_pkg;

    localparam int N_LINES = 2;
    localparam int LSEL_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1;

    typedef enum logic {
        STORE_FF    = 1'b0,
        STORE_LATCH = 1'b1
    } store_mode_e;

    // MSB first: per-line sense, input mode, input line, output line,
    // output source, data inversion, three-state inversion
    typedef struct packed {
        logic [N_LINES-1:0] line_inv;
        store_mode_e        in_mode;
        logic [LSEL_W-1:0]  in_line;
        logic [LSEL_W-1:0]  out_line;
        logic               out_reg;
        logic               out_inv;
        logic               z_inv;
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);

    function automatic logic pick_line(input logic [N_LINES-1:0] lines,
                                       input logic [LSEL_W-1:0]  sel);
        return lines[sel];
    endfunction

endpackage

// File: rtl/pio_cfg_reg.sv
`timescale 1ns/1ps
module pio_cfg_reg
    import pio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_active,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output cell_cfg_t        cfg
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (cfg_active && cfg_we) begin
            cfg <= cell_cfg_t'(cfg_wdata);
        end
    end

endmodule

// File: rtl/pio_in_store.sv
`timescale 1ns/1ps
module pio_in_store
    import pio_pkg::*;
(
    input  logic        eff_clk,
    input  logic        clr,
    input  store_mode_e mode,
    input  logic        d,
    output logic        q
);

    logic ff_q;
    logic lat_q;

    // edge element: active edge is the rise of the sense-corrected line
    always_ff @(posedge eff_clk or posedge clr) begin
        if (clr) begin
            ff_q <= 1'b0;
        end else begin
            ff_q <= d;
        end
    end

    // level element: open while the sense-corrected line is low
    always_latch begin
        if (clr) begin
            lat_q <= 1'b0;
        end else if (!eff_clk) begin
            lat_q <= d;
        end
    end

    assign q = (mode == STORE_LATCH) ? lat_q : ff_q;

endmodule

// File: rtl/pio_out_path.sv
`timescale 1ns/1ps
module pio_out_path (
    input  logic eff_clk,
    input  logic clr,
    input  logic core_o,
    input  logic core_t,
    input  logic out_reg,
    input  logic out_inv,
    input  logic z_inv,
    output logic oq,
    output logic drv_val,
    output logic drv_z
);

    always_ff @(posedge eff_clk or posedge clr) begin
        if (clr) begin
            oq <= 1'b0;
        end else begin
            oq <= core_o;
        end
    end

    assign drv_val = (out_reg ? oq : core_o) ^ out_inv;
    assign drv_z   = core_t ^ z_inv;

endmodule

// File: rtl/pio_cell.sv
`timescale 1ns/1ps
module pio_cell
    import pio_pkg::*;
(
    input  logic               cfg_clk,
    input  logic               rst_n,
    input  logic               cfg_active,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic [N_LINES-1:0] clk_line,
    input  logic               core_o,
    input  logic               core_t,
    output logic               core_i,
    output logic               core_q,
    inout  wire                pad
);

    cell_cfg_t          cfg_q;
    logic [N_LINES-1:0] eff_line;
    logic               in_eff;
    logic               out_eff;
    logic               clr;
    logic               out_q;
    logic               drv_val;
    logic               drv_z;

    assign clr = !rst_n || cfg_active;

    pio_cfg_reg u_cfg (
        .clk        (cfg_clk),
        .rst_n      (rst_n),
        .cfg_active (cfg_active),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg        (cfg_q)
    );

    // sense correction is done once per shared line
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        assign eff_line[g] = clk_line[g] ^ cfg_q.line_inv[g];
    end

    assign in_eff  = pick_line(eff_line, cfg_q.in_line);
    assign out_eff = pick_line(eff_line, cfg_q.out_line);

    pio_in_store u_in (
        .eff_clk (in_eff),
        .clr     (clr),
        .mode    (cfg_q.in_mode),
        .d       (pad),
        .q       (core_q)
    );

    pio_out_path u_out (
        .eff_clk (out_eff),
        .clr     (clr),
        .core_o  (core_o),
        .core_t  (core_t),
        .out_reg (cfg_q.out_reg),
        .out_inv (cfg_q.out_inv),
        .z_inv   (cfg_q.z_inv),
        .oq      (out_q),
        .drv_val (drv_val),
        .drv_z   (drv_z)
    );

    assign pad    = drv_z ? 1'bz : drv_val;
    assign core_i = pad;

endmodule

// File: rtl/pio_cell_chk.sv
`timescale 1ns/1ps
module pio_cell_chk
    import pio_pkg::*;
(
    input logic      cfg_clk,
    input logic      rst_n,
    input logic      cfg_active,
    input cell_cfg_t cfg,
    input logic      eff_in,
    input logic      eff_out,
    input logic      core_i,
    input logic      core_q,
    input logic      oq
);

    AST_CFG_CLEARS: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        cfg_active |-> (core_q == 1'b0 && oq == 1'b0)); // R6

    AST_LATCH_OPEN: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (cfg.in_mode == STORE_LATCH && !eff_in && !cfg_active) |-> core_q == core_i); // R3

    AST_LATCH_HOLD: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (cfg.in_mode == STORE_LATCH && eff_in && $past(eff_in) && !cfg_active
         && !$past(cfg_active) && $past(rst_n)) |-> $stable(core_q)); // R3

    AST_FF_HOLD: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (cfg.in_mode == STORE_FF && !(eff_in && !$past(eff_in)) && !cfg_active
         && !$past(cfg_active) && $past(rst_n)) |-> $stable(core_q)); // R2

    AST_OUT_HOLD: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (!(eff_out && !$past(eff_out)) && !cfg_active && !$past(cfg_active)
         && $past(rst_n)) |-> $stable(oq)); // R10

endmodule

bind pio_cell pio_cell_chk u_chk (
    .cfg_clk    (cfg_clk),
    .rst_n      (rst_n),
    .cfg_active (cfg_active),
    .cfg        (cfg_q),
    .eff_in     (in_eff),
    .eff_out    (out_eff),
    .core_i     (core_i),
    .core_q     (core_q),
    .oq         (out_q)
);

// File: tb/test_pio_cell.sv
`timescale 1ns/1ps
module test_pio_cell;
    import pio_pkg::*;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               cfg_active;
    logic               cfg_we;
    logic [CFG_W-1:0]   cfg_wdata;
    logic [N_LINES-1:0] clk_line;
    logic               core_o;
    logic               core_t;
    wire                core_i;
    wire                core_q;
    wire                pad;
    logic               tb_drv_en;
    logic               tb_pad;

    assign pad = tb_drv_en ? tb_pad : 1'bz;

    always #2.5 clk = ~clk;

    pio_cell i_pio_cell (
        .cfg_clk    (cfg_clk_w),
        .rst_n      (rst_n),
        .cfg_active (cfg_active),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .clk_line   (clk_line),
        .core_o     (core_o),
        .core_t     (core_t),
        .core_i     (core_i),
        .core_q     (core_q),
        .pad        (pad)
    );
    wire cfg_clk_w;
    assign cfg_clk_w = clk;

    // reference model state
    cell_cfg_t m_cfg;
    logic      m_iq;
    logic      m_oq;
    integer    n_cmp = 0;
    integer    n_bad = 0;
    string     g_tag = "";
    bit        done  = 1'b0;

    function automatic logic m_eff(input int l);
        return clk_line[l] ^ m_cfg.line_inv[l];
    endfunction

    function automatic logic m_z();
        return core_t ^ m_cfg.z_inv;
    endfunction

    function automatic logic m_drv();
        return (m_cfg.out_reg ? m_oq : core_o) ^ m_cfg.out_inv;
    endfunction

    function automatic logic m_pad();
        return m_z() ? tb_pad : m_drv();
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string qt;
        string pt;
        qt = (m_cfg.in_mode == STORE_LATCH) ? "R3 R4 R5" : "R2 R4 R5";
        if (m_z()) pt = "R9";
        else if (m_cfg.out_reg) pt = "R7 R8 R9 R10";
        else pt = "R7 R8 R9";
        if (!rst_n) qt = "R6";
        chk({qt, g_tag}, core_q, m_iq);
        chk({"R1", g_tag}, core_i, m_pad());
        chk({pt, g_tag}, pad, m_pad());
    endtask

    // one cycle: compare, then a clock-line step, then a data step
    task automatic step(input bit do_chk);
        logic oi, oo, ni, no;
        int   k;
        @(posedge clk);
        #1;
        if (do_chk) compare_all();
        @(negedge clk);
        oi = m_eff(int'(m_cfg.in_line));
        oo = m_eff(int'(m_cfg.out_line));
        k = int'($urandom % N_LINES);
        if ($urandom % 2 == 0) clk_line[k] = ~clk_line[k];
        ni = m_eff(int'(m_cfg.in_line));
        no = m_eff(int'(m_cfg.out_line));
        if (!oo && no) m_oq = core_o;
        if (m_cfg.in_mode == STORE_LATCH) begin
            if (!ni) m_iq = m_pad();
        end else if (!oi && ni) begin
            m_iq = m_pad();
        end
        if (!rst_n) begin m_iq = 1'b0; m_oq = 1'b0; end
        #1;
        core_o    = 1'($urandom);
        core_t    = 1'($urandom);
        tb_pad    = 1'($urandom);
        tb_drv_en = m_z();
        if (m_cfg.in_mode == STORE_LATCH && !m_eff(int'(m_cfg.in_line))) m_iq = m_pad();
        if (!rst_n) begin m_iq = 1'b0; m_oq = 1'b0; end
    endtask

    // write the configuration word; act=0 issues a strobe that must be ignored
    task automatic cfg_write(input cell_cfg_t c, input bit act);
        cfg_active = act;
        cfg_we     = 1'b1;
        cfg_wdata  = c;
        if (act) begin
            m_iq = 1'b0;
            m_oq = 1'b0;
            tb_drv_en = 1'b0;
        end
        @(posedge clk);
        #1;
        if (act) chk("R6", core_q, 1'b0);
        @(negedge clk);
        cfg_active = 1'b0;
        cfg_we     = 1'b0;
        if (act) m_cfg = c;
        tb_drv_en = m_z();
        if (m_cfg.in_mode == STORE_LATCH && !m_eff(int'(m_cfg.in_line))) m_iq = m_pad();
        #1;
    endtask

    function automatic cell_cfg_t rand_cfg();
        cell_cfg_t c;
        c = cell_cfg_t'(CFG_W'($urandom));
        // keep a registered loop-back off the input element's own line
        if (c.out_reg && c.in_line == c.out_line) c.out_line = ~c.in_line;
        return c;
    endfunction

    function automatic cell_cfg_t mk(input logic [1:0] inv, input store_mode_e md,
                                     input logic il, input logic ol, input logic orr,
                                     input logic oi, input logic zi);
        cell_cfg_t c;
        c.line_inv = inv;
        c.in_mode  = md;
        c.in_line  = il;
        c.out_line = ol;
        c.out_reg  = orr;
        c.out_inv  = oi;
        c.z_inv    = zi;
        return c;
    endfunction

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n      = 1'b0;
        cfg_active = 1'b0;
        cfg_we     = 1'b0;
        cfg_wdata  = '0;
        clk_line   = '0;
        core_o     = 1'b0;
        core_t     = 1'b1;
        tb_pad     = 1'b1;
        tb_drv_en  = 1'b1;
        m_cfg      = '0;
        m_iq       = 1'b0;
        m_oq       = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R6 reset", core_q, 1'b0);
        chk("R9 reset release", pad, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R2: edge capture, normal and inverted sense on each line
        cfg_write(mk(2'b00, STORE_FF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0), 1'b1); run(200);
        cfg_write(mk(2'b10, STORE_FF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0), 1'b1); run(200);
        // R3: latch, both senses
        cfg_write(mk(2'b00, STORE_LATCH, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0), 1'b1); run(200);
        cfg_write(mk(2'b11, STORE_LATCH, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1), 1'b1); run(200);
        // R4 R5: sense of line 0 used by the output element on line 0
        cfg_write(mk(2'b01, STORE_FF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1), 1'b1); run(200);

        // R11: write strobe without cfg_active is ignored
        g_tag = " R11";
        cfg_write(~m_cfg, 1'b0);
        run(100);
        g_tag = "";

        // random configurations
        for (int j = 0; j < 20; j++) begin
            cfg_write(rand_cfg(), 1'b1);
            run(200);
        end

        // R6: mid-run reset clears storage and configuration
        @(negedge clk);
        rst_n = 1'b0;
        m_iq = 1'b0;
        m_oq = 1'b0;
        m_cfg = '0;
        tb_drv_en = 1'b0;
        @(posedge clk);
        #1;
        tb_drv_en = m_z();
        #1;
        run(20);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        run(100);
        cfg_write(mk(2'b11, STORE_LATCH, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0), 1'b1); run(300);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule